// File: doc/BRIEF.md
# Link Parity Error Monitor

This block sits behind the receiver of a serial forward link. Every received word carries one parity bit. The monitor checks each word that arrives while the link reports lock, and counts the words whose parity is wrong. The parity scheme is even: a word fails when the XOR of its data bits and its parity bit is 1.

The running count is a 16-bit saturating value. It is shown live as two byte-wide outputs. It can also be read through a small byte read port. Reading the low byte captures the high byte in a shadow register, so a low-then-high read sequence always returns one consistent 16-bit value. When lock drops, the count clears.

An active-low pass output stays high while no error has been seen recently. It drops for a fixed number of clock cycles after each failing word, and a further failure during that window starts the window again.

Top module: `parity_err_monitor`

## Requirements
- R1: A word sampled with `lock_i`=1 and `word_vld_i`=1 whose data bits XOR parity bit equals 1 increments the 16-bit count by one at that clock edge; a word whose XOR equals 0 leaves the count unchanged.
- R2: A word is ignored when `lock_i`=0 or `word_vld_i`=0 at the sampling edge: neither the count nor `pass_n_o` reacts.
- R3: The count saturates at 0xFFFF; further failing words leave it at 0xFFFF.
- R4: A clock edge with `lock_i`=0 sets the count to 0.
- R5: `pass_n_o` is low for exactly PULSE_LEN (16) cycles, starting right after the edge that samples a failing word; otherwise it is high.
- R6: A failing word sampled while `pass_n_o` is low restarts the low window, giving PULSE_LEN more low cycles from that edge.
- R7: `cnt_lo_o` and `cnt_hi_o` show bits 7:0 and 15:8 of the count. When `rd_en_i`=1, the read port puts the selected byte on `rd_data_o` at that edge: `rd_addr_i`=0 selects the low byte, 1 selects the shadowed high byte. Otherwise `rd_data_o` holds its value.
- R8: A read of address 0 copies the count's high byte into the shadow at the same edge. A later read of address 1 returns that copy, even if the count has changed since.
- R9: After reset the count is 0, `pass_n_o` is 1, `rd_data_o` is 0 and the shadow is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_i | input | 1 | Link lock status from the receiver |
| word_vld_i | input | 1 | Received word strobe |
| word_data_i | input | DATA_W | Received word data bits |
| word_par_i | input | 1 | Received parity bit |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 1 | Read select: 0 low byte, 1 high byte |
| rd_data_o | output | 8 | Registered read data |
| cnt_lo_o | output | 8 | Live low byte of the error count |
| cnt_hi_o | output | 8 | Live high byte of the error count |
| pass_n_o | output | 1 | Active-low error pulse indicator |

## Verification
The bench builds the block with its default parameters: a 24-bit word, a 16-bit count and a 16-cycle pass pulse. With a 16-bit count, the saturation limit is reached by streaming about 65,540 failing words back to back, which fits well within the run. The 16-cycle pulse is short enough to measure the full low window and to place a restarting error in the middle of it. With the count at 0x00FF, a further error makes the high byte change between the two halves of a read, so the shadow capture is tested.

// File: rtl/pem_pkg.sv
package pem_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } rd_sel_e;

    typedef struct packed {
        logic hit;   // word qualified for checking
        logic fail;  // qualified word failed even parity
    } chk_res_t;

endpackage

// File: rtl/pem_parity_check.sv
module pem_parity_check
    import pem_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              lock_i,
    input  logic              vld_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              par_i,
    output chk_res_t          res_o
);
    logic odd;

    always_comb begin
        odd        = ^{data_i, par_i};
        res_o.hit  = lock_i & vld_i;
        res_o.fail = lock_i & vld_i & odd;
    end
endmodule

// File: rtl/pem_err_counter.sv
module pem_err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/pem_pass_pulse.sv
module pem_pass_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic pass_n_o
);
    localparam int TW = $clog2(PULSE_LEN + 1);
    localparam logic [TW-1:0] LOAD = TW'(PULSE_LEN);

    logic [TW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (trig_i) begin
            left_q <= LOAD;
        end else if (left_q != '0) begin
            left_q <= left_q - TW'(1);
        end
    end

    assign pass_n_o = (left_q == '0);
endmodule

// File: rtl/pem_read_port.sv
module pem_read_port
    import pem_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_i,
    input  logic              rd_addr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [BYTE_W-1:0] rd_data_o
);
    logic [BYTE_W-1:0] shadow_q;
    logic [BYTE_W-1:0] data_q;
    rd_sel_e           sel;

    assign sel = rd_sel_e'(rd_addr_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            data_q   <= '0;
        end else if (rd_en_i) begin
            if (sel == SEL_LO) begin
                data_q   <= cnt_i[BYTE_W-1:0];
                shadow_q <= cnt_i[2*BYTE_W-1:BYTE_W];
            end else begin
                data_q <= shadow_q;
            end
        end
    end

    assign rd_data_o = data_q;
endmodule

// File: rtl/parity_err_monitor.sv
module parity_err_monitor
    import pem_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_i,
    input  logic              word_vld_i,
    input  logic [DATA_W-1:0] word_data_i,
    input  logic              word_par_i,
    input  logic              rd_en_i,
    input  logic              rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic [7:0]        cnt_lo_o,
    output logic [7:0]        cnt_hi_o,
    output logic              pass_n_o
);
    localparam int CNT_W = 2 * BYTE_W;

    chk_res_t         res;
    logic [CNT_W-1:0] cnt;

    pem_parity_check #(.DATA_W(DATA_W)) u_chk (
        .lock_i (lock_i),
        .vld_i  (word_vld_i),
        .data_i (word_data_i),
        .par_i  (word_par_i),
        .res_o  (res)
    );

    pem_err_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear_i (~lock_i),
        .inc_i   (res.fail),
        .cnt_o   (cnt)
    );

    pem_pass_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .trig_i   (res.fail),
        .pass_n_o (pass_n_o)
    );

    pem_read_port #(.CNT_W(CNT_W)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .cnt_i     (cnt),
        .rd_data_o (rd_data_o)
    );

    assign cnt_lo_o = cnt[BYTE_W-1:0];
    assign cnt_hi_o = cnt[CNT_W-1:BYTE_W];
endmodule

// File: rtl/parity_err_monitor_chk.sv
module parity_err_monitor_chk #(
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              lock_i,
    input logic              word_vld_i,
    input logic [DATA_W-1:0] word_data_i,
    input logic              word_par_i,
    input logic [7:0]        cnt_lo_o,
    input logic [7:0]        cnt_hi_o,
    input logic              pass_n_o
);
    logic [15:0] c;
    logic        bad;
    assign c   = {cnt_hi_o, cnt_lo_o};
    assign bad = lock_i && word_vld_i && (^{word_data_i, word_par_i});

    a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
        (bad && c != 16'hFFFF) |=> (c == $past(c) + 16'd1));

    a_r2_ignore_no_valid: assert property (@(posedge clk) disable iff (rst)
        (lock_i && !word_vld_i) |=> $stable(c));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (c == 16'hFFFF) |=> (c == 16'hFFFF || c == 16'h0000));

    a_r4_clear_on_unlock: assert property (@(posedge clk) disable iff (rst)
        !lock_i |=> (c == 16'h0000));

    a_r5_pass_drops: assert property (@(posedge clk) disable iff (rst)
        bad |=> !pass_n_o);
endmodule

bind parity_err_monitor parity_err_monitor_chk #(.DATA_W(DATA_W)) u_pem_chk (
    .clk         (clk),
    .rst         (rst),
    .lock_i      (lock_i),
    .word_vld_i  (word_vld_i),
    .word_data_i (word_data_i),
    .word_par_i  (word_par_i),
    .cnt_lo_o    (cnt_lo_o),
    .cnt_hi_o    (cnt_hi_o),
    .pass_n_o    (pass_n_o)
);

// File: tb/parity_err_monitor_test.sv
module parity_err_monitor_test;
    localparam int DW = 24;
    localparam int PL = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lock_i = 1'b0;
    logic word_vld_i = 1'b0;
    logic [DW-1:0] word_data_i = '0;
    logic word_par_i = 1'b0;
    logic rd_en_i = 1'b0;
    logic rd_addr_i = 1'b0;
    logic [7:0] rd_data_o, cnt_lo_o, cnt_hi_o;
    logic pass_n_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int exp_cnt = 0;

    always #2 clk = ~clk;

    parity_err_monitor #(.DATA_W(DW), .PULSE_LEN(PL)) uut (
        .clk(clk), .rst(rst), .lock_i(lock_i), .word_vld_i(word_vld_i),
        .word_data_i(word_data_i), .word_par_i(word_par_i),
        .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .cnt_lo_o(cnt_lo_o), .cnt_hi_o(cnt_hi_o), .pass_n_o(pass_n_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic check_cnt(input string req);
        int a;
        a = {cnt_hi_o, cnt_lo_o};
        check(a == exp_cnt, req, a, exp_cnt);
    endtask

    // bad=1 sends a word with a wrong parity bit
    task automatic send(input logic [DW-1:0] d, input bit bad, input bit vld);
        @(negedge clk);
        word_data_i = d;
        word_par_i  = (^d) ^ bad;
        word_vld_i  = vld;
        @(negedge clk);
        word_vld_i  = 1'b0;
    endtask

    task automatic rd(input bit a, output logic [7:0] v);
        @(negedge clk);
        rd_en_i = 1'b1;
        rd_addr_i = a;
        @(negedge clk);
        rd_en_i = 1'b0;
        v = rd_data_o;
    endtask

    task automatic unlock_clear();
        @(negedge clk);
        lock_i = 1'b0;
        @(negedge clk);
        lock_i = 1'b1;
        exp_cnt = 0;
    endtask

    task automatic t_reset();
        check(cnt_lo_o == 0 && cnt_hi_o == 0, "R9 count", {cnt_hi_o, cnt_lo_o}, 0);
        check(pass_n_o == 1'b1, "R9 pass_n", pass_n_o, 1);
        check(rd_data_o == 0, "R9 rd_data", rd_data_o, 0);
    endtask

    task automatic t_count_basic();
        logic [7:0] v;
        send(24'hA5A5A5, 0, 1); check_cnt("R1 good word");
        send(24'h000001, 1, 1); exp_cnt++; check_cnt("R1 bad word");
        send(24'hFFFFFF, 1, 1); exp_cnt++; check_cnt("R1 second bad word");
        send(24'h123456, 0, 1); check_cnt("R1 good word after errors");
        rd(0, v); check(v == 8'(exp_cnt), "R7 read low", v, exp_cnt);
        rd(1, v); check(v == 0, "R7 read high", v, 0);
    endtask

    task automatic t_ignored();
        repeat (PL + 2) @(negedge clk);
        send(24'h00000F, 1, 0);
        check_cnt("R2 no valid");
        check(pass_n_o == 1, "R2 no pulse without valid", pass_n_o, 1);
        @(negedge clk);
        lock_i = 1'b0;
        word_data_i = 24'h00000F; word_par_i = 1'b0; word_vld_i = 1'b1;
        @(negedge clk);
        word_vld_i = 1'b0;
        check(pass_n_o == 1, "R2 no pulse while unlocked", pass_n_o, 1);
        lock_i = 1'b1;
        exp_cnt = 0;
        @(negedge clk);
        check_cnt("R2 unlocked word not counted");
    endtask

    task automatic t_unlock_clear();
        send(24'h1, 1, 1); send(24'h3, 0, 1); send(24'h7, 1, 1);
        exp_cnt = 2; check_cnt("R4 before unlock");
        unlock_clear();
        check_cnt("R4 cleared on unlock");
    endtask

    task automatic t_pulse();
        int low;
        repeat (PL + 2) @(negedge clk);
        send(24'h10, 1, 1); exp_cnt++;
        low = 0;
        for (int i = 0; i < 40; i++) begin
            if (!pass_n_o) low++;
            @(negedge clk);
        end
        check(low == PL, "R5 pulse width", low, PL);
        check(pass_n_o == 1, "R5 pass high after", pass_n_o, 1);
    endtask

    task automatic t_restart();
        int low;
        send(24'h20, 1, 1); exp_cnt++;
        repeat (9) @(negedge clk);
        check(pass_n_o == 0, "R6 low mid pulse", pass_n_o, 0);
        send(24'h40, 1, 1); exp_cnt++;
        low = 0;
        for (int i = 0; i < 40; i++) begin
            if (!pass_n_o) low++;
            @(negedge clk);
        end
        check(low == PL, "R6 restarted width", low, PL);
        check_cnt("R6 count");
    endtask

    task automatic t_shadow();
        logic [7:0] v;
        unlock_clear();
        @(negedge clk);
        word_vld_i = 1'b1;
        word_data_i = 24'h1; word_par_i = 1'b0;
        repeat (255) @(negedge clk);
        word_vld_i = 1'b0;
        exp_cnt = 255; check_cnt("R8 setup 0x00FF");
        rd(0, v); check(v == 8'hFF, "R8 low byte", v, 8'hFF);
        send(24'h1, 1, 1); exp_cnt++;
        check_cnt("R8 count moved to 0x0100");
        rd(1, v); check(v == 8'h00, "R8 shadowed high byte", v, 0);
        rd(0, v); rd(1, v); check(v == 8'h01, "R8 fresh high byte", v, 1);
    endtask

    task automatic t_saturate();
        logic [7:0] v;
        unlock_clear();
        @(negedge clk);
        word_vld_i = 1'b1;
        word_data_i = 24'h3; word_par_i = 1'b1;
        repeat (65540) @(negedge clk);
        word_vld_i = 1'b0;
        exp_cnt = 16'hFFFF; check_cnt("R3 saturated");
        send(24'h5, 1, 1); check_cnt("R3 stays saturated");
        rd(0, v); check(v == 8'hFF, "R3 read low", v, 8'hFF);
        rd(1, v); check(v == 8'hFF, "R3 read high", v, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        lock_i = 1'b1;
        t_count_basic();
        t_ignored();
        t_unlock_clear();
        t_pulse();
        t_restart();
        t_shadow();
        t_saturate();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule